// File: doc/BRIEF.md
# RAM Controller Interrupt and Configuration Registers

This block is the software-visible control face of an on-chip RAM controller. It collects eleven hardware error and event sources into a sticky status register and gates them through a mask to produce a single level interrupt. The mask cannot be written directly. Software unmasks sources by writing ones to an "irq-on" port and masks them by writing ones to an "irq-off" port. Neither port stores anything. Status bits are cleared by writing ones to them.

The block also holds a 4-bit error-control setting and a read-only implementation word that reports the RAM size chosen by a parameter. It also holds a read-only ready-debug word and a read-only view of a failing-address value supplied by neighbouring capture logic. Access is through a simple 32-bit register bus with a word address, a write flag and byte enables. Only full-word accesses take effect. Read data and the access-error flag are registered and valid one cycle after the request.

Top module: `ramctl_irq_regs`

## Requirements
- R1: After synchronous reset: status reads 0x000, mask reads 0x7FF, error-control reads 0xF, irq_o is 0 and bus_err is 0.
- R2: A high bit of evt_i during a clock cycle sets the matching status bit (word offset 1, bits [10:0]), and the bit stays set until software clears it. Status bits [31:11] read as zero.
- R3: Writing 1 to a status bit clears it, and writing 0 leaves it alone. If an event and a clear hit the same bit in the same cycle, the bit ends set.
- R4: A write to the irq-on port (offset 3) clears every mask bit (offset 2, bits [10:0]) written as 1. The port reads as zero.
- R5: A write to the irq-off port (offset 4) sets every mask bit written as 1. The port reads as zero.
- R6: A direct write to the mask offset has no effect on the mask.
- R7: irq_o is high exactly when some bit of status AND NOT mask is set. It changes at the same clock edge as the state update that causes it.
- R8: Error-control (offset 0) is read/write in bits [3:0]. Bits [31:4] read as zero.
- R9: The implementation word (offset 6) reports the size code in bits [3:0]: 64 KiB=0, 128 KiB=1, 256 KiB=2, 512 KiB=3, 1 MiB=4 (default 4). Writes have no effect. Any other size fails elaboration.
- R10: The ready-debug word (offset 7) reads 0xFFFF in bits [15:0] and ignores writes.
- R11: An access with any byte enable low is ignored: a write changes nothing, and a read returns zero. bus_err is high in the cycle after such a request.
- R12: Offsets above 7 read as zero, and writes to them are ignored.
- R13: Offset 5 returns fail_addr_i[19:0] in bits [19:0], with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 4 | Byte enables; all must be high for a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered partial-access error flag |
| evt_i | input | 11 | Hardware event pulses, one per status bit |
| fail_addr_i | input | 20 | Failing-address value from capture logic |
| irq_o | output | 1 | Level interrupt |

## Verification
A hardware event and a software clear of the same status bit can land in the same clock cycle. The bench provokes this by driving the event pulse during the very cycle that writes the clear. It judges the result by reading status back and seeing the bit still set with irq_o still high. It then repeats the clear alone to confirm that the clear does work. A mask update and a status change can also coincide, so irq_o is sampled right after each enabling, disabling or clearing write rather than after a later read.

// File: rtl/ramctl_pkg.sv
`timescale 1ns/1ps
package ramctl_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int NSRC   = 11;
  localparam int ERRC_W = 4;
  localparam int IMPL_W = 4;
  localparam int RDY_W  = 16;

  // word offsets; software depends on these
  localparam int OFF_ERRCTL = 0;
  localparam int OFF_STATUS = 1;
  localparam int OFF_MASK   = 2;
  localparam int OFF_IRQON  = 3;
  localparam int OFF_IRQOFF = 4;
  localparam int OFF_FAIL   = 5;
  localparam int OFF_IMPL   = 6;
  localparam int OFF_RDY    = 7;

  typedef enum logic [3:0] {
    SEL_ERRCTL, SEL_STATUS, SEL_MASK, SEL_IRQON,
    SEL_IRQOFF, SEL_FAIL, SEL_IMPL, SEL_RDY, SEL_NONE
  } reg_sel_e;

  typedef struct packed {
    logic errctl;
    logic status;
    logic irq_on;
    logic irq_off;
  } wr_stb_t;

  function automatic logic size_ok(int kib);
    return (kib == 64) || (kib == 128) || (kib == 256) ||
           (kib == 512) || (kib == 1024);
  endfunction

  function automatic logic [IMPL_W-1:0] size_code(int kib);
    logic [IMPL_W-1:0] c;
    c = '0;
    for (int i = 0; i < 5; i++)
      if (kib == (64 << i)) c = IMPL_W'(i);
    return c;
  endfunction
endpackage

// File: rtl/ramctl_bus_dec.sv
`timescale 1ns/1ps
module ramctl_bus_dec
  import ramctl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output reg_sel_e          sel,
  output wr_stb_t           wstb,
  output logic              rd_fire,
  output logic              bad_acc
);
  logic full_word;
  logic ok;

  assign full_word = &be;
  assign ok        = req & full_word;
  assign bad_acc   = req & ~full_word;
  assign rd_fire   = ok & ~we;

  always_comb begin
    if      (addr == ADDR_W'(OFF_ERRCTL)) sel = SEL_ERRCTL;
    else if (addr == ADDR_W'(OFF_STATUS)) sel = SEL_STATUS;
    else if (addr == ADDR_W'(OFF_MASK))   sel = SEL_MASK;
    else if (addr == ADDR_W'(OFF_IRQON))  sel = SEL_IRQON;
    else if (addr == ADDR_W'(OFF_IRQOFF)) sel = SEL_IRQOFF;
    else if (addr == ADDR_W'(OFF_FAIL))   sel = SEL_FAIL;
    else if (addr == ADDR_W'(OFF_IMPL))   sel = SEL_IMPL;
    else if (addr == ADDR_W'(OFF_RDY))    sel = SEL_RDY;
    else                                  sel = SEL_NONE;
  end

  always_comb begin
    wstb         = '0;
    wstb.errctl  = ok & we & (sel == SEL_ERRCTL);
    wstb.status  = ok & we & (sel == SEL_STATUS);
    wstb.irq_on  = ok & we & (sel == SEL_IRQON);
    wstb.irq_off = ok & we & (sel == SEL_IRQOFF);
  end
endmodule

// File: rtl/ramctl_irq_core.sv
`timescale 1ns/1ps
module ramctl_irq_core #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] wdata,
  input  logic            clr_stb,
  input  logic            on_stb,
  input  logic            off_stb,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] mask_q,
  output logic            irq_q
);
  logic [NSRC-1:0] status_d;
  logic [NSRC-1:0] mask_d;
  logic [NSRC-1:0] pend_d;

  // per-source cell: event beats clear, irq-on/off touch only bits written as 1
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign status_d[i] = evt[i] | (status_q[i] & ~(clr_stb & wdata[i]));
    assign mask_d[i]   = (off_stb & wdata[i]) | (mask_q[i] & ~(on_stb & wdata[i]));
    assign pend_d[i]   = status_d[i] & ~mask_d[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_q    <= |pend_d;
    end
  end
endmodule

// File: rtl/ramctl_cfg_rd.sv
`timescale 1ns/1ps
module ramctl_cfg_rd
  import ramctl_pkg::*;
#(
  parameter int                NSRC_P    = 11,
  parameter int                FAIL_W    = 20,
  parameter logic [IMPL_W-1:0] SIZE_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fire,
  input  reg_sel_e          sel,
  input  logic              errc_wr,
  input  logic [ERRC_W-1:0] errc_wdata,
  input  logic [NSRC_P-1:0] status,
  input  logic [NSRC_P-1:0] mask,
  input  logic [FAIL_W-1:0] fail_addr,
  output logic [DATA_W-1:0] rdata_q
);
  logic [ERRC_W-1:0] errc_q;
  logic [IMPL_W-1:0] impl_q;
  logic [RDY_W-1:0]  rdy_q;
  logic [DATA_W-1:0] mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      errc_q <= '1;
      impl_q <= SIZE_CODE;
      rdy_q  <= '1;
    end else if (errc_wr) begin
      errc_q <= errc_wdata;
    end
  end

  always_comb begin
    mux = '0;
    case (sel)
      SEL_ERRCTL: mux = DATA_W'(errc_q);
      SEL_STATUS: mux = DATA_W'(status);
      SEL_MASK:   mux = DATA_W'(mask);
      SEL_FAIL:   mux = DATA_W'(fail_addr);
      SEL_IMPL:   mux = DATA_W'(impl_q);
      SEL_RDY:    mux = DATA_W'(rdy_q);
      default:    mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_fire ? mux : '0;
  end
endmodule

// File: rtl/ramctl_irq_regs.sv
`timescale 1ns/1ps
module ramctl_irq_regs
  import ramctl_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int RAM_KIB = 1024,
  parameter int FAIL_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [FAIL_W-1:0] fail_addr_i,
  output logic              irq_o
);
  localparam logic [IMPL_W-1:0] SIZE_CODE = size_code(RAM_KIB);

  if (!size_ok(RAM_KIB)) begin : g_bad_size
    $error("ramctl_irq_regs: RAM_KIB=%0d is not a supported size", RAM_KIB);
  end

  reg_sel_e        sel;
  wr_stb_t         wstb;
  logic            rd_fire;
  logic            bad_acc;
  logic [NSRC-1:0] status_w;
  logic [NSRC-1:0] mask_w;
  logic            err_q;
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:NSRC];

  ramctl_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req     (bus_req),
    .we      (bus_we),
    .addr    (bus_addr),
    .be      (bus_be),
    .sel     (sel),
    .wstb    (wstb),
    .rd_fire (rd_fire),
    .bad_acc (bad_acc)
  );

  ramctl_irq_core #(.NSRC(NSRC)) u_core (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_i),
    .wdata    (bus_wdata[NSRC-1:0]),
    .clr_stb  (wstb.status),
    .on_stb   (wstb.irq_on),
    .off_stb  (wstb.irq_off),
    .status_q (status_w),
    .mask_q   (mask_w),
    .irq_q    (irq_o)
  );

  ramctl_cfg_rd #(
    .NSRC_P    (NSRC),
    .FAIL_W    (FAIL_W),
    .SIZE_CODE (SIZE_CODE)
  ) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_fire    (rd_fire),
    .sel        (sel),
    .errc_wr    (wstb.errctl),
    .errc_wdata (bus_wdata[ERRC_W-1:0]),
    .status     (status_w),
    .mask       (mask_w),
    .fail_addr  (fail_addr_i),
    .rdata_q    (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= bad_acc;
  end
  assign bus_err = err_q;
endmodule

// File: rtl/ramctl_irq_chk.sv
`timescale 1ns/1ps
module ramctl_irq_chk
  import ramctl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BE_W-1:0]   bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_err,
  input logic [NSRC-1:0]   evt_i,
  input logic              irq_o,
  input logic [NSRC-1:0]   status_q,
  input logic [NSRC-1:0]   mask_q
);
  logic full_wr;
  assign full_wr = bus_req & bus_we & (&bus_be);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_q == '0 && mask_q == '1 && !irq_o));

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  assert_irqon_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (full_wr && bus_addr == ADDR_W'(OFF_IRQON))
      |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0));

  assert_irqoff_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (full_wr && bus_addr == ADDR_W'(OFF_IRQOFF))
      |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(status_q & ~mask_q)));

  assert_partial_err_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !(&bus_be)) |=> (bus_err && $stable(mask_q)));
endmodule

bind ramctl_irq_regs ramctl_irq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_err   (bus_err),
  .evt_i     (evt_i),
  .irq_o     (irq_o),
  .status_q  (status_w),
  .mask_q    (mask_w)
);

// File: tb/ramctl_irq_regs_tb.sv
`timescale 1ns/1ps
module ramctl_irq_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [10:0] evt_i = '0;
  logic [19:0] fail_addr_i = 20'hABCDE;
  logic        irq_o;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] rv;
  logic        ev;

  always #4 clk = ~clk;

  ramctl_irq_regs dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .evt_i(evt_i),
    .fail_addr_i(fail_addr_i), .irq_o(irq_o)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input int addr, input logic [31:0] wd,
                        input logic [3:0] be, input logic [10:0] evt,
                        output logic [31:0] rd, output logic err);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = addr[5:0];
    bus_wdata = wd; bus_be = be; evt_i = evt;
    @(negedge clk);
    rd = bus_rdata; err = bus_err;
    bus_req = 1'b0; bus_we = 1'b0; evt_i = '0; bus_be = '0;
  endtask

  task automatic wr(input int addr, input logic [31:0] wd);
    logic [31:0] r; logic e;
    bus_op(1'b1, addr, wd, 4'hF, '0, r, e);
  endtask

  task automatic rd(input int addr, output logic [31:0] r);
    logic e;
    bus_op(1'b0, addr, '0, 4'hF, '0, r, e);
  endtask

  task automatic pulse(input logic [10:0] evt);
    @(negedge clk); evt_i = evt;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic t_reset;
    check("R1", "irq after reset", 32'(irq_o), 0);
    check("R1", "err after reset", 32'(bus_err), 0);
    rd(1, rv); check("R1", "status reset", rv, 32'h0);
    rd(2, rv); check("R1", "mask reset", rv, 32'h7FF);
    rd(0, rv); check("R1", "errctl reset", rv, 32'hF);
  endtask

  task automatic t_events;
    pulse(11'h005);
    rd(1, rv); check("R2", "status after events", rv, 32'h005);
    check("R7", "irq while masked", 32'(irq_o), 0);
    wr(1, 32'hFFFF_F800);
    rd(1, rv); check("R2", "status upper bits and no-op clear", rv, 32'h005);
  endtask

  task automatic t_irqon;
    wr(3, 32'h0000_0001);
    check("R7", "irq after unmask bit0", 32'(irq_o), 1);
    rd(2, rv); check("R4", "mask after irq-on", rv, 32'h7FE);
    rd(3, rv); check("R4", "irq-on reads zero", rv, 0);
  endtask

  task automatic t_irqoff;
    wr(4, 32'h0000_0001);
    check("R7", "irq after remask", 32'(irq_o), 0);
    rd(2, rv); check("R5", "mask after irq-off", rv, 32'h7FF);
    rd(4, rv); check("R5", "irq-off reads zero", rv, 0);
  endtask

  task automatic t_mask_ro;
    wr(2, 32'h0);
    rd(2, rv); check("R6", "mask after direct write", rv, 32'h7FF);
  endtask

  task automatic t_clear;
    wr(3, 32'h7FF);
    check("R7", "irq all unmasked", 32'(irq_o), 1);
    wr(1, 32'h004);
    rd(1, rv); check("R3", "status partial clear", rv, 32'h001);
    check("R7", "irq still pending", 32'(irq_o), 1);
    wr(1, 32'h001);
    check("R7", "irq after last clear", 32'(irq_o), 0);
    rd(1, rv); check("R3", "status fully cleared", rv, 0);
  endtask

  task automatic t_collide;
    logic [31:0] r; logic e;
    pulse(11'h008);
    bus_op(1'b1, 1, 32'h008, 4'hF, 11'h008, r, e);
    check("R3", "event beats same-cycle clear, irq", 32'(irq_o), 1);
    rd(1, rv); check("R3", "event beats same-cycle clear, status", rv, 32'h008);
    wr(1, 32'h008);
    rd(1, rv); check("R3", "clear alone works", rv, 0);
    check("R7", "irq after clear alone", 32'(irq_o), 0);
  endtask

  task automatic t_errctl;
    wr(0, 32'hFFFF_FFF5);
    rd(0, rv); check("R8", "errctl width", rv, 32'h5);
    wr(0, 32'h3);
    rd(0, rv); check("R8", "errctl rewrite", rv, 32'h3);
  endtask

  task automatic t_ro_words;
    wr(6, 32'h0);
    rd(6, rv); check("R9", "impl size code", rv, 32'h4);
    wr(7, 32'h0);
    rd(7, rv); check("R10", "ready-debug", rv, 32'hFFFF);
    fail_addr_i = 20'h1_2345;
    rd(5, rv); check("R13", "fail addr view", rv, 32'h0001_2345);
  endtask

  task automatic t_partial;
    logic [31:0] r; logic e;
    bus_op(1'b1, 0, 32'h0, 4'h3, '0, r, e);
    check("R11", "err on partial write", 32'(e), 1);
    rd(0, rv); check("R11", "errctl untouched", rv, 32'h3);
    bus_op(1'b1, 3, 32'h7FF, 4'h7, '0, r, e);
    rd(2, rv); check("R11", "mask untouched by partial irq-on", rv, 32'h000);
    bus_op(1'b0, 7, 32'h0, 4'h1, '0, r, e);
    check("R11", "partial read data", r, 0);
    check("R11", "err on partial read", 32'(e), 1);
    rd(0, rv); check("R11", "err clears on full access", 32'(bus_err), 0);
  endtask

  task automatic t_unmapped;
    wr(9, 32'hFFFF_FFFF);
    rd(9, rv); check("R12", "unmapped read", rv, 0);
    rd(0, rv); check("R12", "errctl after unmapped write", rv, 32'h3);
    rd(2, rv); check("R12", "mask after unmapped write", rv, 32'h000);
    rd(1, rv); check("R12", "status after unmapped write", rv, 0);
  endtask

  initial begin
    #(8 * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_events;
    t_irqon;
    t_irqoff;
    t_mask_ro;
    t_clear;
    t_collide;
    t_errctl;
    t_ro_words;
    t_partial;
    t_unmapped;
    ev = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule